// File: doc/BRIEF.md
# Pixel Word Byte and Pixel Reorder Stage

This block sits on the 32-bit pixel data path, between the unit that fetches words from memory and the unit that unpacks pixels. It changes the order of the data inside each word in two ways. The first is a pair of endian swaps that can be used on their own or together: one exchanges the two 16-bit halves of the word, and the other exchanges the two bytes inside each half. The second applies only to palette-indexed pixel formats. It reverses the order of the packed pixels, either inside each 16-bit half or inside each byte, with each pixel taken at the width of the current format.

Data enters and leaves on valid/ready streams and passes through a single register stage. The settings are static configuration inputs, sampled at the moment a word is accepted. The endian swaps are applied first, and the pixel reversal then works on the swapped word.

Top module: `pixel_reorder`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1. A word held in the stage is dropped when reset is asserted.
- R2: A word accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high after that same edge, giving a latency of one cycle. With every option off, the word passes through unchanged.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and `in_ready` is 0. Once the stall ends, words leave in the order they were accepted, with none lost and none repeated. When `out_valid` is 0, `in_ready` is 1.
- R4: With `cfg_hw_swap`=1, bits [31:16] and [15:0] of each word exchange places.
- R5: With `cfg_byte_swap`=1, bits [15:8] and [7:0] exchange places, and so do bits [31:24] and [23:16].
- R6: With both swap inputs set to 1, the four bytes of the word come out in reverse order.
- R7: With `cfg_rev_order`=1, `cfg_nib_mode`=0 and a palette format (`cfg_fmt` 0=1 bit, 1=2 bits, 2=4 bits, 3=8 bits per pixel), the pixel groups of that width inside each 16-bit half are reversed. Group 0 sits at the least significant end.
- R8: With `cfg_rev_order`=1 and `cfg_nib_mode`=1, the pixel groups are reversed inside each byte instead. At 8 bits per pixel this leaves the word unchanged.
- R9: With `cfg_fmt` from 4 to 7 (4=16-bit direct colour, 5=24-bit direct colour, 6 and 7 treated as direct), `cfg_rev_order` has no effect on the output.
- R10: When swaps and pixel reversal are both enabled, the output is the reversal applied to the already swapped word.
- R11: With `cfg_rev_order`=0, a palette format and no swaps, the word passes through unchanged whatever the value of `cfg_nib_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hw_swap | input | 1 | Exchange the 16-bit halves of each word |
| cfg_byte_swap | input | 1 | Exchange the bytes within each 16-bit half |
| cfg_rev_order | input | 1 | Reverse the pixel order in palette formats |
| cfg_nib_mode | input | 1 | Reversal unit: 0 = 16-bit half, 1 = byte |
| cfg_fmt | input | 3 | Pixel format code (0..3 palette 1/2/4/8 bit, 4..7 direct) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept a word |
| in_data | input | WORD_W | Input word from memory fetch |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can accept a word |
| out_data | output | WORD_W | Reordered word |

## Verification
The swaps are exercised with the word 0x12345678, where every nibble is distinct, so that a halfword exchange, a byte exchange and a full four-byte reversal each produce a different result that cannot be confused with the others. Reversal is tried at every palette width and with both units. Asymmetric words such as 0x00018000, 0x0000001B and 0x01234567 make a 1-bit or 2-bit reversal differ visibly from a 4-bit or 8-bit one, and show whether the half or the byte was used as the unit. Direct-colour codes with reversal enabled, and reversal with its enable off, show that the gating is applied. A stalled output with a second word waiting shows that data is held and kept in order.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

  localparam int BYTE_W   = 8;
  localparam int HALF_W   = 16;
  localparam int SWAP_W   = 32;
  localparam int NUM_PAL  = 4;   // palette pixel widths 1,2,4,8

  typedef enum logic [2:0] {
    FMT_PAL1  = 3'd0,
    FMT_PAL2  = 3'd1,
    FMT_PAL4  = 3'd2,
    FMT_PAL8  = 3'd3,
    FMT_RGB16 = 3'd4,
    FMT_RGB24 = 3'd5
  } pix_fmt_e;

  // Codes with the top bit clear are palette-indexed.
  function automatic logic fmt_is_palette(input logic [2:0] fmt);
    return !fmt[2];
  endfunction

endpackage

// File: rtl/pxr_swap.sv
module pxr_swap #(
  parameter int WORD_W = 32
) (
  input  logic              hw_swap,
  input  logic              byte_swap,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  import pxr_pkg::*;

  localparam int NUM_LANES = WORD_W / SWAP_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [SWAP_W-1:0] src;
    logic [SWAP_W-1:0] halves;
    logic [SWAP_W-1:0] bytes_o;

    assign src = din[l*SWAP_W +: SWAP_W];

    // halfword exchange first
    assign halves = hw_swap ? {src[HALF_W-1:0], src[SWAP_W-1:HALF_W]} : src;

    // then byte exchange inside each half
    assign bytes_o = byte_swap ?
                     {halves[23:16], halves[31:24], halves[7:0], halves[15:8]} :
                     halves;

    assign dout[l*SWAP_W +: SWAP_W] = bytes_o;
  end

endmodule

// File: rtl/pxr_reverse.sv
module pxr_reverse #(
  parameter int WORD_W = 32
) (
  input  logic              rev_en,
  input  logic              nib_mode,
  input  logic [2:0]        fmt,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  import pxr_pkg::*;

  logic [WORD_W-1:0] cand_half [NUM_PAL];
  logic [WORD_W-1:0] cand_byte [NUM_PAL];

  // One mirrored copy of the word per palette width and per unit size.
  for (genvar p = 0; p < NUM_PAL; p++) begin : g_width
    localparam int PW      = 1 << p;
    localparam int GRP_H   = HALF_W / PW;
    localparam int GRP_B   = BYTE_W / PW;
    localparam int NUM_GRP = WORD_W / PW;

    logic [WORD_W-1:0] mir_h;
    logic [WORD_W-1:0] mir_b;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int SRC_H = (g / GRP_H) * GRP_H + (GRP_H - 1 - (g % GRP_H));
      localparam int SRC_B = (g / GRP_B) * GRP_B + (GRP_B - 1 - (g % GRP_B));
      assign mir_h[g*PW +: PW] = din[SRC_H*PW +: PW];
      assign mir_b[g*PW +: PW] = din[SRC_B*PW +: PW];
    end

    assign cand_half[p] = mir_h;
    assign cand_byte[p] = mir_b;
  end

  always_comb begin
    dout = din;
    if (rev_en && fmt_is_palette(fmt)) begin
      if (nib_mode) dout = cand_byte[fmt[1:0]];
      else          dout = cand_half[fmt[1:0]];
    end
  end

endmodule

// File: rtl/pxr_stage.sv
module pxr_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  // data register carries no reset; only the valid flag needs one
  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

endmodule

// File: rtl/pixel_reorder.sv
module pixel_reorder #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_hw_swap,
  input  logic              cfg_byte_swap,
  input  logic              cfg_rev_order,
  input  logic              cfg_nib_mode,
  input  logic [2:0]        cfg_fmt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);

  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] reordered;

  pxr_swap #(.WORD_W(WORD_W)) u_swap (
    .hw_swap   (cfg_hw_swap),
    .byte_swap (cfg_byte_swap),
    .din       (in_data),
    .dout      (swapped)
  );

  pxr_reverse #(.WORD_W(WORD_W)) u_rev (
    .rev_en   (cfg_rev_order),
    .nib_mode (cfg_nib_mode),
    .fmt      (cfg_fmt),
    .din      (swapped),
    .dout     (reordered)
  );

  pxr_stage #(.WORD_W(WORD_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (reordered),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

endmodule

// File: rtl/pxr_checker.sv
module pxr_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_hw_swap,
  input logic              cfg_byte_swap,
  input logic              cfg_rev_order,
  input logic [2:0]        cfg_fmt,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);

  // R2
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R9
  direct_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !cfg_hw_swap && !cfg_byte_swap && (cfg_fmt >= 3'd4))
    |=> (out_data == $past(in_data)));

  // R6
  full_reverse_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && cfg_hw_swap && cfg_byte_swap && (cfg_fmt >= 3'd4))
    |=> (out_data[31:0] == {$past(in_data[7:0]), $past(in_data[15:8]),
                            $past(in_data[23:16]), $past(in_data[31:24])}));

endmodule

bind pixel_reorder pxr_checker #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_hw_swap   (cfg_hw_swap),
  .cfg_byte_swap (cfg_byte_swap),
  .cfg_rev_order (cfg_rev_order),
  .cfg_fmt       (cfg_fmt),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_data       (in_data),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data)
);

// File: tb/tb_pixel_reorder.sv
module tb_pixel_reorder;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int WATCHDOG   = 5000;
  localparam int NV         = 19;

  // {hw,byte,rev,nib}, fmt, input, expected, requirement number
  localparam logic [74:0] VEC [NV] = '{
    {4'b0000, 3'd4, 32'h12345678, 32'h12345678, 4'd2},  // R2 pass through
    {4'b1000, 3'd4, 32'h12345678, 32'h56781234, 4'd4},  // R4
    {4'b0100, 3'd4, 32'h12345678, 32'h34127856, 4'd5},  // R5
    {4'b1100, 3'd4, 32'h12345678, 32'h78563412, 4'd6},  // R6
    {4'b0010, 3'd2, 32'h12345678, 32'h43218765, 4'd7},  // R7 4-bit in half
    {4'b0011, 3'd2, 32'h12345678, 32'h21436587, 4'd8},  // R8 4-bit in byte
    {4'b0010, 3'd3, 32'h12345678, 32'h34127856, 4'd7},  // R7 8-bit in half
    {4'b0011, 3'd3, 32'h12345678, 32'h12345678, 4'd8},  // R8 8-bit in byte
    {4'b0010, 3'd4, 32'h12345678, 32'h12345678, 4'd9},  // R9 16-bit direct
    {4'b0011, 3'd5, 32'h12345678, 32'h12345678, 4'd9},  // R9 24-bit direct
    {4'b0010, 3'd7, 32'h12345678, 32'h12345678, 4'd9},  // R9 code 7
    {4'b1010, 3'd2, 32'h12345678, 32'h87654321, 4'd10}, // R10 hw + rev
    {4'b0111, 3'd2, 32'h12345678, 32'h43218765, 4'd10}, // R10 byte + rev
    {4'b0010, 3'd0, 32'h00018000, 32'h80000001, 4'd7},  // R7 1-bit
    {4'b0011, 3'd0, 32'h01234567, 32'h80C4A2E6, 4'd8},  // R8 1-bit
    {4'b0010, 3'd1, 32'h0000001B, 32'h0000E400, 4'd7},  // R7 2-bit
    {4'b0011, 3'd1, 32'h1B1B1B1B, 32'hE4E4E4E4, 4'd8},  // R8 2-bit
    {4'b0000, 3'd2, 32'h12345678, 32'h12345678, 4'd11}, // R11 nib 0
    {4'b0001, 3'd0, 32'h01234567, 32'h01234567, 4'd11}  // R11 nib 1
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_hw_swap = 1'b0;
  logic              cfg_byte_swap = 1'b0;
  logic              cfg_rev_order = 1'b0;
  logic              cfg_nib_mode = 1'b0;
  logic [2:0]        cfg_fmt = 3'd4;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [WORD_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [WORD_W-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_reorder #(.WORD_W(WORD_W)) dut (
    .clk           (clk),
    .rst           (rst),
    .cfg_hw_swap   (cfg_hw_swap),
    .cfg_byte_swap (cfg_byte_swap),
    .cfg_rev_order (cfg_rev_order),
    .cfg_nib_mode  (cfg_nib_mode),
    .cfg_fmt       (cfg_fmt),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check(in_ready,   "R1 in_ready in reset",  {31'd0, in_ready},  32'd1);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset release",
          {30'd0, out_valid, in_ready}, 32'd1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cfg_hw_swap, cfg_byte_swap, cfg_rev_order, cfg_nib_mode} = VEC[i][74:71];
      cfg_fmt   = VEC[i][70:68];
      in_data   = VEC[i][67:36];
      in_valid  = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && (out_data == VEC[i][35:4]),
            $sformatf("R%0d vector %0d", VEC[i][3:0], i), out_data, VEC[i][35:4]);
    end

    // R2: valid drops when nothing new follows
    @(negedge clk);
    check(!out_valid, "R2 valid clears when idle", {31'd0, out_valid}, 32'd0);

    // R3: stall with a second word waiting
    cfg_hw_swap = 1'b0; cfg_byte_swap = 1'b0; cfg_rev_order = 1'b0; cfg_fmt = 3'd4;
    out_ready = 1'b0;
    in_data   = 32'hAAAA0001;
    in_valid  = 1'b1;
    @(negedge clk);
    check(out_valid && out_data == 32'hAAAA0001, "R3 first word out", out_data, 32'hAAAA0001);
    check(!in_ready, "R3 ready low while stalled", {31'd0, in_ready}, 32'd0);
    in_data = 32'hBBBB0002;
    @(negedge clk);
    check(out_valid && out_data == 32'hAAAA0001, "R3 data held in stall", out_data, 32'hAAAA0001);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 32'hBBBB0002, "R3 second word in order", out_data, 32'hBBBB0002);
    @(negedge clk);
    check(!out_valid, "R3 no duplicate", {31'd0, out_valid}, 32'd0);

    // R1: reset drops a held word
    out_ready = 1'b0;
    in_data   = 32'hCCCC0003;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset drops held word",
          {30'd0, out_valid, in_ready}, 32'd1);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule